// File: doc/BRIEF.md
# Grouped Prioritised Interrupt Controller

The controller collects up to one hundred interrupt request inputs into twenty-five groups of four. The two lowest-numbered groups are non-maskable: any request bit that newly appears there produces a one-cycle pulse on `nmi_out`. Every other group is maskable. It carries a 3-bit priority level and a 4-bit enable mask. The block always drives `irq_level` with the level of the most urgent group that has an enabled request pending, where a smaller number means more urgent.

The request inputs are already qualified. A source that is high at a clock edge sets its request bit, and that bit stays set until software clears it through the byte-wide register port. Each group owns an 8-byte window: the group index is the byte address divided by 8, and the low three bits select the byte within it. One extra byte, at address `NUM_GROUPS*8`, holds the accepted-group register. This register is read-only.

When the processor accepts an interrupt, it raises `ack_valid` with the level it took. If that level matches `irq_level`, the controller records the winning group. Software can then read the recorded group number, shifted left by two, to find which group it is serving.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, every request bit is 0, every enable mask is 4'b1111, every level is 0, `irq_level` is 7, `nmi_out` and `ack_err` are 0, and the accepted-group byte reads 0.
- R2: A high on `src_in[n]` at a clock edge sets request bit n%4 of group n/4. Byte 0 of a maskable group reads the request bits in [7:4] and request AND enable in [3:0].
- R3: Byte 1 of a maskable group reads the level in [6:4] and the enable mask in [3:0], with bit 7 reading 0. A write to byte 1 loads both fields.
- R4: A write of value W to byte 0 of a maskable group gives request = (request AND W[3:0]) OR (W[7:4] AND W[3:0]). A source that is high in the same cycle still sets its bit.
- R5: Byte 0 of a non-maskable group (group 0 or 1) reads the request bits in [3:0]. A write there clears each request bit whose bit in W[3:0] is 1.
- R6: When any request bit of group 0 or 1 goes from 0 to 1, `nmi_out` is high for the one following cycle.
- R7: `irq_level` reflects the registered state, so it changes in the cycle after the clock edge that changed a request, level or enable. It equals the smallest level among maskable groups that have an enabled request pending. When levels tie, the lower-numbered group wins.
- R8: `irq_level` is 7 when no maskable group has an enabled request pending. A pending group at level 7 never becomes the winner and leaves `irq_level` at 7.
- R9: An acknowledge whose `ack_level` equals `irq_level` records the winning group. The accepted-group byte then reads that group number shifted left by 2.
- R10: The accepted-group byte reads 0 while the recorded group has no enabled request pending. Writes to that address change nothing.
- R11: An acknowledge whose level differs from `irq_level` sets `ack_err`, which stays 1 until reset, and leaves the recorded group unchanged.
- R12: Bytes 2 to 7 of any group, and byte 1 of a non-maskable group, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_GROUPS*4 | Qualified request inputs, bit n goes to group n/4 |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for one byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Processor accepts an interrupt |
| ack_level | input | 3 | Level the processor accepted |
| irq_level | output | 3 | Level of the winning pending group, 7 when idle |
| nmi_out | output | 1 | One-cycle non-maskable interrupt pulse |
| ack_err | output | 1 | Sticky flag for an acknowledge with a mismatched level |

## Verification
The assertions assume that `ack_level` matters only while `ack_valid` is high. They also assume that all inputs are settled at the sampling edge, so the recorded group and the error flag depend only on the state just before that edge. The bench changes every input on the falling clock edge. It drives `ack_valid` for exactly one cycle and never issues a bus write in that same cycle. This keeps the hold check on the recorded group free of any competing update. Request inputs are pulsed for one cycle, so that a later clear cannot be undone by a source that is still held high.

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int NUM_GROUPS = 25,
  parameter int NMI_GROUPS = 2,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*4-1:0] src_in,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic                    ack_valid,
  input  logic [2:0]              ack_level,
  output logic [2:0]              irq_level,
  output logic                    nmi_out,
  output logic                    ack_err
);
  localparam int GW = ADDR_W - 3;
  localparam int WW = $clog2(NUM_GROUPS);
  localparam logic [ADDR_W-1:0] ACC_ADDR = ADDR_W'(NUM_GROUPS * 8);

  logic [3:0] req_q [NUM_GROUPS];
  logic [3:0] en_q  [NUM_GROUPS];
  logic [2:0] lvl_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend;
  logic [NMI_GROUPS-1:0] nmi_set;
  logic [WW-1:0] win_g, acc_q;
  logic [2:0]    win_lvl;
  logic          acc_live;

  wire [GW-1:0] sel_g   = bus_addr[ADDR_W-1:3];
  wire [2:0]    sel_off = bus_addr[2:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : grp
    wire [3:0] src = src_in[g*4 +: 4];
    wire wr0 = bus_wr && sel_g == GW'(g) && sel_off == 3'd0;
    wire wr1 = bus_wr && sel_g == GW'(g) && sel_off == 3'd1;
    logic [3:0] req_nxt;

    if (g < NMI_GROUPS) begin : nmi
      assign req_nxt = (wr0 ? (req_q[g] & ~bus_wdata[3:0]) : req_q[g]) | src;
      assign nmi_set[g] = |(req_nxt & ~req_q[g] & en_q[g]);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_q[g]  <= 4'hF;
          lvl_q[g] <= 3'd0;
        end
      end
    end else begin : msk
      assign req_nxt = (wr0 ? ((req_q[g] & bus_wdata[3:0]) | (bus_wdata[7:4] & bus_wdata[3:0]))
                            : req_q[g]) | src;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          en_q[g]  <= 4'hF;
          lvl_q[g] <= 3'd0;
        end else if (wr1) begin
          en_q[g]  <= bus_wdata[3:0];
          lvl_q[g] <= bus_wdata[6:4];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) req_q[g] <= 4'h0;
      else        req_q[g] <= req_nxt;
    end

    assign pend[g] = |(req_q[g] & en_q[g]);
  end

  always_comb begin
    win_g   = '0;
    win_lvl = 3'd7;
    for (int g = NMI_GROUPS; g < NUM_GROUPS; g++)
      if (pend[g] && lvl_q[g] < win_lvl) begin
        win_g   = WW'(g);
        win_lvl = lvl_q[g];
      end
  end
  assign irq_level = win_lvl;

  wire ack_ok = ack_valid && ack_level == irq_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      ack_err <= 1'b0;
      nmi_out <= 1'b0;
    end else begin
      if (ack_ok) acc_q <= win_g;
      if (ack_valid && !ack_ok) ack_err <= 1'b1;
      nmi_out <= |nmi_set;
    end
  end

  always_comb begin
    acc_live = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (acc_q == WW'(g)) acc_live = pend[g];
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == ACC_ADDR) begin
      if (acc_live) bus_rdata = 8'({acc_q, 2'b00});
    end else begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (sel_g == GW'(g)) begin
          if (g < NMI_GROUPS) begin
            if (sel_off == 3'd0) bus_rdata = {4'h0, req_q[g]};
          end else if (sel_off == 3'd0) begin
            bus_rdata = {req_q[g], req_q[g] & en_q[g]};
          end else if (sel_off == 3'd1) begin
            bus_rdata = {1'b0, lvl_q[g], en_q[g]};
          end
        end
    end
  end

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != irq_level) |=> $stable(acc_q));
  a_r9_latch_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level == irq_level) |=> acc_q == $past(win_g));
  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NUM_GROUPS-1:NMI_GROUPS] == '0) |-> irq_level == 3'd7);
  a_r10_acc_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ACC_ADDR && !ack_valid) |=> $stable(acc_q));
  a_r5_nmi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0 && bus_wdata[0] && !src_in[0]) |=> req_q[0][0] == 1'b0);
endmodule

// File: tb/grp_irq_ctrl_test.sv
`timescale 1ns/1ps
module grp_irq_ctrl_test;
  localparam int NG = 25;
  localparam logic [7:0] ACC = 8'd200;

  logic clk = 0, rst_n = 0;
  logic [NG*4-1:0] src_in = '0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 0, ack_valid = 0;
  logic [2:0] ack_level = '0, irq_level;
  logic nmi_out, ack_err;
  int n_run = 0, n_fail = 0;

  grp_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_valid(ack_valid),
    .ack_level(ack_level), .irq_level(irq_level), .nmi_out(nmi_out), .ack_err(ack_err));

  always #2.5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(string req, input logic [7:0] a, input int exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src_in[n] = 1;
    @(negedge clk); src_in[n] = 0;
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk); ack_valid = 1; ack_level = l;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 irq_level", irq_level, 7);
    check("R1 nmi_out", nmi_out, 0);
    check("R1 ack_err", ack_err, 0);
    rd_chk("R1 enable reset", 8'd17, 8'h0F);
    rd_chk("R1 acc reset", ACC, 0);
  endtask

  task automatic t_map;
    pulse(9);
    rd_chk("R2 group2 byte0", 8'd16, 8'h22);
    check("R7 level follows", irq_level, 0);
    wr(8'd17, 8'h0D);
    rd_chk("R2 masked view", 8'd16, 8'h20);
    check("R8 disabled idle", irq_level, 7);
    wr(8'd17, 8'h0F);
    wr(8'd16, 8'h00);
    rd_chk("R4 clear all", 8'd16, 0);
  endtask

  task automatic t_byte1;
    wr(8'd25, 8'hFF);
    rd_chk("R3 byte1 fields", 8'd25, 8'h7F);
    wr(8'd25, 8'h0F);
  endtask

  task automatic t_masked_write;
    pulse(16); pulse(17);
    rd_chk("R4 before", 8'd32, 8'h33);
    wr(8'd32, 8'h5E);
    rd_chk("R4 masked write", 8'd32, 8'h66);
    wr(8'd32, 8'h00);
  endtask

  task automatic t_nmi;
    @(negedge clk); src_in[1] = 1;
    @(negedge clk); src_in[1] = 0;
    check("R6 nmi pulse", nmi_out, 1);
    @(negedge clk);
    check("R6 nmi one cycle", nmi_out, 0);
    rd_chk("R5 nmi byte0", 8'd0, 8'h02);
    check("R5 nmi not maskable level", irq_level, 7);
    wr(8'd0, 8'h02);
    rd_chk("R5 w1c", 8'd0, 0);
    pulse(5);
    check("R6 group1 nmi", nmi_out, 1);
    rd_chk("R12 nmi byte1", 8'd9, 0);
    wr(8'd8, 8'h0F);
  endtask

  task automatic t_prio;
    wr(8'd25, 8'h2F); wr(8'd41, 8'h2F); wr(8'd57, 8'h4F);
    pulse(28);
    check("R7 single", irq_level, 4);
    pulse(20);
    check("R7 lower wins", irq_level, 2);
    pulse(12);
    check("R7 tie", irq_level, 2);
    ack(2);
    rd_chk("R9 acc tie group3", ACC, 8'h0C);
    wr(8'd24, 8'h00);
    rd_chk("R10 acc lost", ACC, 0);
    ack(2);
    rd_chk("R9 acc group5", ACC, 8'h14);
    check("R11 no err yet", ack_err, 0);
    ack(5);
    check("R11 err set", ack_err, 1);
    rd_chk("R11 latch held", ACC, 8'h14);
    wr(ACC, 8'hFF);
    rd_chk("R10 acc write ignored", ACC, 8'h14);
    @(negedge clk);
    check("R11 err sticky", ack_err, 1);
    wr(8'd40, 8'h00); wr(8'd56, 8'h00);
    check("R8 idle", irq_level, 7);
    wr(8'd49, 8'h7F);
    pulse(24);
    rd_chk("R8 pending lvl7", 8'd48, 8'h11);
    check("R8 lvl7 no win", irq_level, 7);
    wr(8'd48, 8'h00);
  endtask

  task automatic t_unused;
    wr(8'd26, 8'hFF);
    rd_chk("R12 byte2", 8'd26, 0);
    rd_chk("R12 byte7", 8'd31, 0);
    rd_chk("R12 neighbour intact", 8'd25, 8'h2F);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_map;
        t_byte1;
        t_masked_write;
        t_nmi;
        t_prio;
        t_unused;
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule